// File: doc/BRIEF.md
# Sine-Modulated PWM Generator

This block drives one pulse-width-modulated line whose duty cycle follows a sine wave. One period of the sine is held as a table of quantised samples. The table is computed when the design elaborates, so no file has to be loaded. Each sample is held for one full PWM period, and the table is read cyclically. A one-bit rate select picks one of two prescale values. Those values set how fast the PWM counter runs, and so how long one sine period lasts.

With a 100 MHz clock and the defaults, select 0 gives a prescale of 95. One sample then lasts 95 × 4096 = 389120 clocks, which is close to a 1 Hz sine. Select 1 gives a prescale of 27. One sample then lasts 110592 clocks, which is close to 3.5 Hz. The block also brings out the current table index and a one-clock strobe at each sample boundary. A downstream low-pass filter or a monitor can use them to follow the waveform.

Top module: `sine_pwm_gen`

## Requirements
- R1: Table entry i holds round(A + A·sin(2πi/N)), where N = 2^IDX_BITS and A = (2^SAMP_BITS − 1)/2. The defaults are 256 entries of 12 bits, so the values run from 0 to 4095.
- R2: The prescaler gives one tick every DIV clocks. DIV is PRESC_SLOW (default 95) while the active select is 0, and PRESC_FAST (default 27) while it is 1.
- R3: The PWM counter counts ticks from 0 up to 2^SAMP_BITS − 1 and then returns to 0. A return to 0 marks a sample boundary, so boundaries are DIV × 2^SAMP_BITS clocks apart.
- R4: pwm_o is registered and trails the compare by one clock. Count pwm_o over the clocks after one strobe, up to and including the next strobe. That count is exactly sample × DIV, where sample is the table value at the index shown during that period. A sample of 0 gives no high clocks. The largest sample keeps the line low for only DIV clocks.
- R5: At each boundary, idx_o advances by one modulo 2^IDX_BITS and strobe_o is high for exactly one clock. idx_o changes at no other time.
- R6: rate_sel_i passes through a two-flop synchroniser. It takes effect only at the next sample boundary, so the period in progress keeps its old length.
- R7: A synchronous active-low reset clears the prescaler and the PWM counter. It sets idx_o to 0, holds pwm_o and strobe_o low, and sets the active select to 0. The first period after reset lasts DIV × 2^SAMP_BITS clocks.
- R8: After the last entry the index returns to 0, so the sine repeats without a gap or a repeated sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel_i | input | 1 | Sine rate select (0 slow, 1 fast), asynchronous to the block |
| pwm_o | output | 1 | Modulated PWM output |
| idx_o | output | IDX_BITS | Table index of the sample now being played |
| strobe_o | output | 1 | One-clock pulse at each sample boundary |

## Verification
The assertions assume three things. Reset is low at the first clock edge. Both prescale values are at least 1. A PWM period spans at least two ticks, so two strobes are never adjacent. The select input may change at any time, and the assertions only require that the active rate moves at a boundary. The bench holds reset low from time zero. It changes the select only on falling clock edges and well inside a period. It uses small prescale and table widths, which keep every period in the same legal range while still reaching the table's extremes and its wrap.

// File: rtl/sine_pwm_pkg.sv
// Package: sine_pwm_pkg
// Shared helpers for the sine PWM generator. It computes the quantised sine
// value for one table entry. Assumes idx_bits <= 16 and samp_bits <= 16.
package sine_pwm_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Quantised sine sample: midscale plus midscale times sin, rounded.
    function automatic int sine_value(input int i, input int idx_bits, input int samp_bits);
        real half;
        real phase;
        half  = real'((1 << samp_bits) - 1) / 2.0;
        phase = TWO_PI * real'(i) / real'(1 << idx_bits);
        return $rtoi(half + half * $sin(phase) + 0.5);
    endfunction

endpackage

// File: rtl/sine_pwm_rom.sv
// Module: sine_pwm_rom
// Read-only sine table with a combinational read. Every entry is a constant
// computed from the package function, so the table folds into logic.
// Assumes addr_i is always a legal index (the width guarantees it).
module sine_pwm_rom #(
    parameter int IDX_BITS  = 8,
    parameter int SAMP_BITS = 12
) (
    input  logic [IDX_BITS-1:0]  addr_i,
    output logic [SAMP_BITS-1:0] data_o
);
    import sine_pwm_pkg::*;

    localparam int DEPTH = 1 << IDX_BITS;

    logic [SAMP_BITS-1:0] table_w [DEPTH];

    // One constant per entry, generated from the sine formula.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = SAMP_BITS'(sine_value(g, IDX_BITS, SAMP_BITS));
    end

    // Combinational read port.
    assign data_o = table_w[addr_i];

endmodule

// File: rtl/sine_pwm_prescaler.sv
// Module: sine_pwm_prescaler
// Divides the clock by one of two constants and gives a one-clock tick.
// Assumes sel_i changes only when the count has just restarted (a boundary).
module sine_pwm_prescaler #(
    parameter int PRESC_SLOW = 95,
    parameter int PRESC_FAST = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic tick_o
);
    localparam int MAX_DIV = (PRESC_SLOW > PRESC_FAST) ? PRESC_SLOW : PRESC_FAST;
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(PRESC_SLOW - 1);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(PRESC_FAST - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_w;

    // Last count value for the active rate.
    assign last_w = sel_i ? LAST_FAST : LAST_SLOW;
    assign tick_o = (cnt_q == last_w);

    // Count up and restart after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sine_pwm_core.sv
// Module: sine_pwm_core
// PWM counter and comparator. The counter steps once per tick and wraps at
// full scale. The output is a registered compare against the current sample.
// Assumes sample_i stays steady within one PWM period.
module sine_pwm_core #(
    parameter int SAMP_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [SAMP_BITS-1:0] sample_i,
    output logic [SAMP_BITS-1:0] cnt_o,
    output logic                 wrap_o,
    output logic                 pwm_o
);
    localparam logic [SAMP_BITS-1:0] CNT_MAX = '1;

    logic [SAMP_BITS-1:0] cnt_q;
    logic                 pwm_q;

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == CNT_MAX);
    assign pwm_o  = pwm_q;

    // PWM counter: one step per tick, natural wrap at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered compare: high while the count is below the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (cnt_q < sample_i);
        end
    end

endmodule

// File: rtl/sine_pwm_seq.sv
// Module: sine_pwm_seq
// Sample sequencer. It synchronises the rate select and steps the table
// index at each boundary, applying the new rate there. It also raises the
// boundary strobe. Assumes wrap_i lasts one clock per PWM period.
module sine_pwm_seq #(
    parameter int IDX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_async_i,
    input  logic                wrap_i,
    output logic                sel_active_o,
    output logic [IDX_BITS-1:0] idx_o,
    output logic                strobe_o
);
    logic                sync1_q;
    logic                sync2_q;
    logic                sel_q;
    logic [IDX_BITS-1:0] idx_q;
    logic                strobe_q;

    assign sel_active_o = sel_q;
    assign idx_o        = idx_q;
    assign strobe_o     = strobe_q;

    // Two-flop synchroniser for the asynchronous rate select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= sel_async_i;
            sync2_q <= sync1_q;
        end
    end

    // Boundary actions: new rate, next index, strobe pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            idx_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wrap_i;
            if (wrap_i) begin
                sel_q <= sync2_q;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sine_pwm_gen.sv
// Module: sine_pwm_gen (top)
// Sine-modulated PWM generator. It is built from a prescaler, a PWM
// counter with a comparator, a sample sequencer and a constant sine table.
// Assumes one clock domain. rate_sel_i may be asynchronous.
module sine_pwm_gen #(
    parameter int IDX_BITS   = 8,
    parameter int SAMP_BITS  = 12,
    parameter int PRESC_SLOW = 95,
    parameter int PRESC_FAST = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rate_sel_i,
    output logic                pwm_o,
    output logic [IDX_BITS-1:0] idx_o,
    output logic                strobe_o
);
    logic                 tick_w;
    logic                 wrap_w;
    logic                 sel_act_w;
    logic [SAMP_BITS-1:0] sample_w;
    logic [SAMP_BITS-1:0] pwm_cnt_w;

    sine_pwm_prescaler #(
        .PRESC_SLOW (PRESC_SLOW),
        .PRESC_FAST (PRESC_FAST)
    ) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_act_w),
        .tick_o (tick_w)
    );

    sine_pwm_seq #(
        .IDX_BITS (IDX_BITS)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_async_i  (rate_sel_i),
        .wrap_i       (wrap_w),
        .sel_active_o (sel_act_w),
        .idx_o        (idx_o),
        .strobe_o     (strobe_o)
    );

    sine_pwm_rom #(
        .IDX_BITS  (IDX_BITS),
        .SAMP_BITS (SAMP_BITS)
    ) rom_i (
        .addr_i (idx_o),
        .data_o (sample_w)
    );

    sine_pwm_core #(
        .SAMP_BITS (SAMP_BITS)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .sample_i (sample_w),
        .cnt_o    (pwm_cnt_w),
        .wrap_o   (wrap_w),
        .pwm_o    (pwm_o)
    );

endmodule

// File: rtl/sine_pwm_gen_chk.sv
// Module: sine_pwm_gen_chk
// Property checker for sine_pwm_gen. It is attached by bind below.
// Assumes reset is low at the first clock edge.
module sine_pwm_gen_chk #(
    parameter int IDX_BITS  = 8,
    parameter int SAMP_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwm_o,
    input logic [IDX_BITS-1:0]  idx_o,
    input logic                 strobe_o,
    input logic                 tick_w,
    input logic                 sel_act_w,
    input logic [SAMP_BITS-1:0] sample_w,
    input logic [SAMP_BITS-1:0] pwm_cnt_w
);
    localparam logic [SAMP_BITS-1:0] CNT_MAX = '1;

    // R3: a tick at full scale produces a boundary strobe next clock.
    assert_wrap_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && pwm_cnt_w == CNT_MAX) |=> strobe_o);

    // R4: a zero sample never drives the line high.
    assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_w == '0) |=> !pwm_o);

    // R5: the index advances by one exactly when the strobe shows.
    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (idx_o == IDX_BITS'($past(idx_o) + 1'b1)));

    // R5: the index holds between boundaries.
    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(idx_o));

    // R5: the strobe lasts one clock.
    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R6: the active rate moves only at a boundary.
    assert_sel_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(sel_act_w));

    // R7: reset leaves the outputs quiet and the index at zero.
    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (!pwm_o && !strobe_o && idx_o == '0));

endmodule

bind sine_pwm_gen sine_pwm_gen_chk #(
    .IDX_BITS  (IDX_BITS),
    .SAMP_BITS (SAMP_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_o     (pwm_o),
    .idx_o     (idx_o),
    .strobe_o  (strobe_o),
    .tick_w    (tick_w),
    .sel_act_w (sel_act_w),
    .sample_w  (sample_w),
    .pwm_cnt_w (pwm_cnt_w)
);

// File: tb/sine_pwm_gen_tb_top.sv
// Directed bench for sine_pwm_gen. It uses small widths and prescale values
// so that full sine cycles fit in a short run.
module sine_pwm_gen_tb_top;

    localparam int  IDX_BITS   = 4;
    localparam int  SAMP_BITS  = 6;
    localparam int  PRESC_SLOW = 3;
    localparam int  PRESC_FAST = 2;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NSAMP      = 1 << IDX_BITS;
    localparam int  TICKS      = 1 << SAMP_BITS;
    localparam int  WATCHDOG   = 150000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rate_sel = 1'b0;
    logic                pwm;
    logic [IDX_BITS-1:0] idx;
    logic                strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sine_pwm_gen #(
        .IDX_BITS   (IDX_BITS),
        .SAMP_BITS  (SAMP_BITS),
        .PRESC_SLOW (PRESC_SLOW),
        .PRESC_FAST (PRESC_FAST)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel),
        .pwm_o      (pwm),
        .idx_o      (idx),
        .strobe_o   (strobe)
    );

    // Expected table value, taken straight from the R1 formula.
    function automatic int exp_sample(input int i);
        real half;
        half = real'((1 << SAMP_BITS) - 1) / 2.0;
        return $rtoi(half + half * $sin(6.283185307179586 * real'(i) / real'(NSAMP)) + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_strobe();
        do @(negedge clk); while (!strobe);
    endtask

    // Measure one period from the current strobe up to the next one.
    // The select can be changed toggle_at clocks into the period.
    task automatic one_window(input int toggle_at, input logic new_sel,
                              output int i0, output int len, output int hi);
        i0 = int'(idx);
        len = 0;
        hi = 0;
        do begin
            @(negedge clk);
            len++;
            hi += int'(pwm);
            if (len == toggle_at) rate_sel = new_sel;
        end while (!strobe && len < 4 * TICKS * PRESC_SLOW);
    endtask

    // Scenario: reset state, then the first period after release (R7).
    task automatic t_reset();
        int n = 0;
        int hi = 0;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0 && strobe == 1'b0, "R7 outputs low in reset", int'(pwm) + int'(strobe), 0);
        check(idx == '0, "R7 index zero in reset", int'(idx), 0);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
            hi += int'(pwm);
        end while (!strobe && n < 4 * TICKS * PRESC_SLOW);
        check(n == TICKS * PRESC_SLOW, "R7 first period length", n, TICKS * PRESC_SLOW);
        check(hi == exp_sample(0) * PRESC_SLOW, "R4 first period high time", hi, exp_sample(0) * PRESC_SLOW);
        check(int'(idx) == 1, "R5 index after first boundary", int'(idx), 1);
    endtask

    // Scenario: full sine cycle plus wrap at one rate (R1..R5, R8).
    task automatic t_rate(input logic sel, input int div, input string tag);
        int i0, len, hi, pass_len, pass_hi, pass_idx;
        bit saw_wrap;
        bit saw_max;
        bit saw_zero;
        pass_len = 0;
        pass_hi = 0;
        pass_idx = 0;
        saw_wrap = 1'b0;
        saw_max = 1'b0;
        saw_zero = 1'b0;
        rate_sel = sel;
        sync_strobe();
        sync_strobe();
        for (int k = 0; k < NSAMP + 2; k++) begin
            one_window(-1, sel, i0, len, hi);
            if (len == TICKS * div) pass_len++;
            else check(1'b0, {tag, " R3 period length"}, len, TICKS * div);
            if (hi == exp_sample(i0) * div) pass_hi++;
            else check(1'b0, {tag, " R4 high time"}, hi, exp_sample(i0) * div);
            if (int'(idx) == (i0 + 1) % NSAMP) pass_idx++;
            else check(1'b0, {tag, " R5 index step"}, int'(idx), (i0 + 1) % NSAMP);
            if (i0 == NSAMP - 1 && idx == '0) saw_wrap = 1'b1;
            if (exp_sample(i0) == TICKS - 1 && hi == (TICKS - 1) * div) saw_max = 1'b1;
            if (exp_sample(i0) == 0 && hi == 0) saw_zero = 1'b1;
        end
        check(pass_len == NSAMP + 2, {tag, " R2 R3 all periods DIV x 2^SAMP_BITS"}, pass_len, NSAMP + 2);
        check(pass_hi == NSAMP + 2, {tag, " R1 R4 all high times match table"}, pass_hi, NSAMP + 2);
        check(pass_idx == NSAMP + 2, {tag, " R5 all index steps"}, pass_idx, NSAMP + 2);
        check(saw_wrap, {tag, " R8 index wraps to zero"}, int'(saw_wrap), 1);
        check(saw_max, {tag, " R4 full-scale sample low for DIV clocks"}, int'(saw_max), 1);
        check(saw_zero, {tag, " R4 zero sample never high"}, int'(saw_zero), 1);
    endtask

    // Scenario: a select change mid-period waits for the boundary (R6).
    task automatic t_switch();
        int i0, len, hi;
        rate_sel = 1'b1;
        sync_strobe();
        sync_strobe();
        one_window(10, 1'b0, i0, len, hi);
        check(len == TICKS * PRESC_FAST, "R6 period in progress keeps fast length", len, TICKS * PRESC_FAST);
        one_window(-1, 1'b0, i0, len, hi);
        check(len == TICKS * PRESC_SLOW, "R6 next period uses slow length", len, TICKS * PRESC_SLOW);
        check(hi == exp_sample(i0) * PRESC_SLOW, "R4 high time after rate change", hi, exp_sample(i0) * PRESC_SLOW);
        one_window(20, 1'b1, i0, len, hi);
        check(len == TICKS * PRESC_SLOW, "R6 period in progress keeps slow length", len, TICKS * PRESC_SLOW);
        one_window(-1, 1'b1, i0, len, hi);
        check(len == TICKS * PRESC_FAST, "R6 next period uses fast length", len, TICKS * PRESC_FAST);
    endtask

    // Scenario: reset in mid-run restores the reset state (R7).
    task automatic t_mid_reset();
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pwm == 1'b0 && strobe == 1'b0 && idx == '0, "R7 mid-run reset clears outputs",
              int'(pwm) + int'(strobe) + int'(idx), 0);
        rate_sel = 1'b0;
        t_reset();
    endtask

    initial begin
        t_reset();
        t_rate(1'b0, PRESC_SLOW, "slow");
        t_rate(1'b1, PRESC_FAST, "fast");
        t_switch();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule